// File: doc/BRIEF.md
# Burst Pulse Generator

This block drives a single pulse line with a periodic rectangular wave, timed in ticks of the system clock. Three configuration words, held steady by the surrounding logic, set the following:

- the length of one period in ticks;
- how many ticks at the start of each period the line stays low;
- how many periods to produce.

A one-cycle start strobe launches a finite burst. An idle flag reports when the generator is producing nothing.

The period-count word is encoded. Zero turns the generator off. The all-ones value makes it run without end and without a start strobe. Any other value is an exact number of periods, counted from a start strobe. A period length of zero also turns the generator off.

The controller is a three-state machine:

- `ST_IDLE`: the line is low and the flag is high.
- `ST_BURST`: a finite burst is being delivered.
- `ST_FREE`: free-running mode.

Transitions:

- `ST_IDLE` to `ST_BURST`: a start strobe arrives with a finite count.
- `ST_IDLE` to `ST_FREE`: the count word is all-ones.
- `ST_BURST` restarts in place on a new start strobe.
- `ST_BURST` to `ST_FREE`: the count word becomes all-ones.
- `ST_BURST` to `ST_IDLE`: the last period completes, or the configuration becomes disabled.
- `ST_FREE` restarts its phase on a start strobe.
- `ST_FREE` to `ST_IDLE`: the count word stops being all-ones, or the configuration becomes disabled.

Top module: `pgen_burst_top`

## Requirements
- R1: After reset `pulse_out` is 0 and `done` is 1.
- R2: While running, the tick index within a period starts at 0 in the cycle after the launch. `pulse_out` is 0 for tick indices below `cfg_low` and 1 for the rest of the period. With `cfg_low` = 0 the line is high for the whole period.
- R3: When `cfg_count` is 0 or `cfg_period` is 0, the generator is disabled. `pulse_out` stays 0, `done` is 1 from the next cycle on, and `start` has no effect.
- R4: With `cfg_count` N in the range 1 to 0xFFFFFFFE, a start produces exactly N periods (N × `cfg_period` cycles). After the last period, `done` returns to 1 and `pulse_out` returns to 0.
- R5: With `cfg_count` = 0xFFFFFFFF and a non-zero period, the generator runs from the next cycle without a start strobe and keeps `done` at 0. Changing `cfg_count` away from all-ones stops it on the next cycle.
- R6: A `start` strobe clears both the tick counter and the period counter. A strobe in the middle of a burst therefore yields a full N periods beginning from tick 0.
- R7: When `cfg_low` is greater than or equal to `cfg_period`, `pulse_out` stays 0 for every period. Periods are still counted and `done` is still 0 during the burst.
- R8: `done` is 0 in every cycle of a finite burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_period | input | CNT_W | Period length in ticks; 0 disables |
| cfg_low | input | CNT_W | Ticks held low at the start of each period |
| cfg_count | input | CNT_W | Periods to deliver; 0 off, all-ones endless |
| start | input | 1 | One-cycle strobe that launches or restarts a burst |
| pulse_out | output | 1 | Pulse line |
| done | output | 1 | 1 when the generator is idle |

## Verification
The hardest situation to reach is a start strobe arriving in the middle of a running burst. The counters must then clear without losing or adding a period, and the effect is visible only in the phase and total length of the wave that follows. The stimulus launches a burst, checks the first seven ticks, then strobes start again at a known tick. It then expects a complete fresh burst of N periods from tick 0, followed by `done` in the exact cycle the last period ends. The switch out of endless mode by a change of the count word is also driven mid-period, and the bench checks that the line drops at once.

// File: rtl/pgen_pkg.sv
package pgen_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_FREE  = 2'd2
    } pgen_state_e;
endpackage

// File: rtl/pgen_phase_ctr.sv
module pgen_phase_ctr #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] tick,
    output logic             wrap
);
    localparam int EXT_W = CNT_W + 1;

    logic [EXT_W-1:0] tick_nxt;

    assign tick_nxt = {1'b0, tick} + EXT_W'(1);
    assign wrap     = (tick_nxt >= {1'b0, period});

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick <= '0;
        end else if (clr) begin
            tick <= '0;
        end else if (run) begin
            tick <= wrap ? '0 : tick_nxt[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/pgen_burst_ctr.sv
module pgen_burst_ctr #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] target,
    output logic             last
);
    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] periods_done;
    logic [EXT_W-1:0] periods_nxt;

    assign periods_nxt = {1'b0, periods_done} + EXT_W'(1);
    assign last        = (periods_nxt >= {1'b0, target});

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            periods_done <= '0;
        end else if (clr) begin
            periods_done <= '0;
        end else if (inc) begin
            periods_done <= periods_nxt[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/pgen_fsm.sv
module pgen_fsm
    import pgen_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic             wrap,
    input  logic             last,
    output pgen_state_e      state,
    output logic             phase_clr,
    output logic             phase_run,
    output logic             cnt_clr,
    output logic             cnt_inc,
    output logic             running,
    output logic             done
);
    localparam logic [CNT_W-1:0] CNT_ENDLESS = '1;

    pgen_state_e state_nxt;
    logic        disabled;
    logic        endless;

    assign disabled = (cfg_period == '0) || (cfg_count == '0);
    assign endless  = (cfg_count == CNT_ENDLESS);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (disabled)     state_nxt = ST_IDLE;
                else if (endless) state_nxt = ST_FREE;
                else if (start)   state_nxt = ST_BURST;
            end
            ST_BURST: begin
                if (disabled)             state_nxt = ST_IDLE;
                else if (endless)         state_nxt = ST_FREE;
                else if (start)           state_nxt = ST_BURST;
                else if (wrap && last)    state_nxt = ST_IDLE;
            end
            ST_FREE: begin
                if (disabled || !endless) state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        phase_clr = 1'b0;
        phase_run = 1'b0;
        cnt_clr   = 1'b0;
        cnt_inc   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                phase_clr = (state_nxt != ST_IDLE);
                cnt_clr   = (state_nxt != ST_IDLE);
            end
            ST_BURST: begin
                phase_clr = start && !disabled;
                cnt_clr   = start && !disabled;
                phase_run = 1'b1;
                cnt_inc   = wrap;
            end
            ST_FREE: begin
                phase_clr = start && !disabled;
                phase_run = 1'b1;
            end
            default: ;
        endcase
        running = (state != ST_IDLE);
        done    = (state == ST_IDLE);
    end
endmodule

// File: rtl/pgen_burst_top.sv
module pgen_burst_top
    import pgen_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_low,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic             start,
    output logic             pulse_out,
    output logic             done
);
    pgen_state_e      state;
    logic             phase_clr, phase_run, cnt_clr, cnt_inc;
    logic             running, wrap, last;
    logic [CNT_W-1:0] tick;

    pgen_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_period(cfg_period), .cfg_count(cfg_count),
        .wrap(wrap), .last(last), .state(state),
        .phase_clr(phase_clr), .phase_run(phase_run),
        .cnt_clr(cnt_clr), .cnt_inc(cnt_inc),
        .running(running), .done(done)
    );

    pgen_phase_ctr #(.CNT_W(CNT_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .clr(phase_clr), .run(phase_run),
        .period(cfg_period), .tick(tick), .wrap(wrap)
    );

    pgen_burst_ctr #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc),
        .target(cfg_count), .last(last)
    );

    assign pulse_out = running && (tick >= cfg_low);

    // Idle line stays low
    assert_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !pulse_out);

    // Zero count or zero period forces idle on the next cycle
    assert_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_count == '0 || cfg_period == '0) |=> done);

    // All-ones count keeps the generator running
    assert_endless_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_count == '1 && cfg_period != '0) |=> !done);

    // Accepted start resets the phase
    assert_start_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && cfg_period != '0 && cfg_count != '0) |=> (tick == '0 && !done));

    // Final period of a finite burst returns to idle
    assert_burst_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BURST && wrap && last && !start && cfg_count != '1
         && cfg_count != '0 && cfg_period != '0) |=> done);
endmodule

// File: tb/test_pgen_burst_top.sv
`timescale 1ns/1ps
module test_pgen_burst_top;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] cfg_period = '0;
    logic [W-1:0] cfg_low = '0;
    logic [W-1:0] cfg_count = '0;
    logic         start = 1'b0;
    logic         pulse_out, done;
    int           n_vec = 0;
    int           n_bad = 0;
    bit           finished = 1'b0;

    always #2.5 clk = ~clk;

    pgen_burst_top #(.CNT_W(W)) i_pgen_burst_top (
        .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_low(cfg_low),
        .cfg_count(cfg_count), .start(start), .pulse_out(pulse_out), .done(done)
    );

    task automatic chk(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic expect_wave(input string req, input int period, input int low,
                               input int ncyc, input logic exp_done);
        for (int k = 0; k < ncyc; k++) begin
            chk(req, "pulse_out", W'(pulse_out), W'((k % period) >= low));
            chk(req, "done", W'(done), W'(exp_done));
            @(negedge clk);
        end
    endtask

    task automatic expect_idle(input string req, input int ncyc);
        for (int k = 0; k < ncyc; k++) begin
            chk(req, "idle pulse_out", W'(pulse_out), '0);
            chk(req, "idle done", W'(done), W'(1));
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk("R1", "reset pulse_out", W'(pulse_out), '0);
        chk("R1", "reset done", W'(done), W'(1));
    endtask

    task automatic t_finite(input int p, input int l, input int n);
        cfg_period = W'(p); cfg_low = W'(l); cfg_count = W'(n);
        pulse_start();
        expect_wave("R4_R2_R8", p, l, n * p, 1'b0);
        expect_idle("R4", 4);
    endtask

    task automatic t_low_ge_period();
        cfg_period = W'(4); cfg_low = W'(6); cfg_count = W'(3);
        pulse_start();
        expect_wave("R7", 4, 6, 12, 1'b0);
        expect_idle("R7", 3);
    endtask

    task automatic t_disabled();
        cfg_period = W'(5); cfg_low = W'(2); cfg_count = '0;
        @(negedge clk);
        pulse_start();
        expect_idle("R3 zero count", 10);
        cfg_period = '0; cfg_count = W'(3);
        @(negedge clk);
        pulse_start();
        expect_idle("R3 zero period", 10);
    endtask

    task automatic t_restart();
        cfg_period = W'(5); cfg_low = W'(2); cfg_count = W'(3);
        pulse_start();
        expect_wave("R6 first", 5, 2, 7, 1'b0);
        pulse_start();
        expect_wave("R6 restarted", 5, 2, 15, 1'b0);
        expect_idle("R6", 3);
    endtask

    task automatic t_endless();
        cfg_period = W'(5); cfg_low = W'(2); cfg_count = '1;
        @(negedge clk);
        expect_wave("R5 endless", 5, 2, 43, 1'b0);
        cfg_count = '0;
        @(negedge clk);
        expect_idle("R5 stop", 4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_finite(5, 2, 3);
        t_finite(3, 0, 4);
        t_finite(1, 0, 1);
        t_finite(7, 6, 2);
        t_low_ge_period();
        t_disabled();
        t_restart();
        t_endless();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule